// File: doc/BRIEF.md
# Dual-Sync Manchester Word Encoder

This block turns one 16-bit parallel word into a serial word that takes 20 bit times on a Manchester II bus. Each word opens with a three-bit-time synchronizing pattern. A select input picks one of two sync shapes, one for command words and one for data words. Sixteen data bits follow, most significant first, and an odd parity bit closes the word. Each bit time is split into two halves of `HALF_TICKS` clocks. The defaults give a 1 µs bit at a 50 MHz clock. The serial line is driven as a complementary pair. Both pins sit low while nothing is being sent.

An external controller paces the encoder with three single-cycle strobes. The start strobe opens a word. The data strobe marks the one clock in which the parallel bus is captured, which is the last clock of the sync. The end strobe marks the last clock of the word. The controller raises a send request and holds the encoder enable high. If the request is still high when a word ends, the next word follows with no gap. Dropping the enable stops a word on the next clock.

Top module: `manch_word_tx`

## Requirements
- R1: While `rst_n` is low, `tx_pos`, `tx_neg`, `start_stb`, `data_stb` and `end_stb` are all 0.
- R2: When idle, a clock edge that sees `enc_en` and `send_req` both high starts a word. `start_stb` is then high for exactly the next clock cycle, which is the first cycle of the word.
- R3: The sync covers half-bits 0 to 5. `sync_cmd` is sampled on the edge that starts the word. When it is 1, `tx_pos` is high for half-bits 0 to 2 and low for half-bits 3 to 5. When it is 0, the levels are the reverse. Changing `sync_cmd` after the start has no effect on the word in progress.
- R4: Half-bits 6 to 37 carry `data_in` bit 15 down to bit 0, two half-bits per bit. A 1 is sent high then low on `tx_pos`, and a 0 is sent low then high. Each half lasts `HALF_TICKS` clocks.
- R5: Half-bits 38 and 39 carry a parity bit, Manchester coded as in R4. The parity bit makes the count of ones over the 16 data bits plus parity odd.
- R6: `data_in` is captured on the edge that ends the single cycle in which `data_stb` is high. That cycle is the last clock of half-bit 5. The value of `data_in` in any other cycle has no effect on the word.
- R7: `end_stb` is high only in the last clock of half-bit 39, which is clock 40*`HALF_TICKS`-1 counted from the `start_stb` cycle. At most one of the three strobes is high in any cycle.
- R8: If `enc_en` and `send_req` are high in the `end_stb` cycle, the next word starts in the very next cycle and raises `start_stb` there. Otherwise the encoder returns to idle.
- R9: While a word is in progress, `tx_neg` is the complement of `tx_pos`. While idle, both are 0.
- R10: With `enc_en` low, no word starts. If `enc_en` falls during a word, the word is abandoned on the next edge: both line outputs go to 0 and no `end_stb` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_en | input | 1 | Encoder enable; low blocks or aborts transmission |
| send_req | input | 1 | Request to send a word |
| sync_cmd | input | 1 | 1 selects the command sync, 0 the data sync |
| data_in | input | DATA_W | Parallel word, sampled in the data-strobe cycle |
| tx_pos | output | 1 | Serial line, true phase |
| tx_neg | output | 1 | Serial line, complement phase |
| start_stb | output | 1 | First clock of a word |
| data_stb | output | 1 | Clock in which `data_in` is captured |
| end_stb | output | 1 | Last clock of a word |

## Verification
The words sent use the alternating pattern A5C3, all zeros, all ones and a word with only its lowest bit set. Together they tell apart a swapped Manchester phase, reversed bit order, even versus odd parity and an off-by-one in the shifter. Each command-sync word is set against a data-sync word, and `sync_cmd` is flipped after the start, so a sync taken late or inverted shows up. The bench holds a decoy value on `data_in` everywhere outside the capture cycle, which exposes a capture at the wrong clock. Back-to-back requests, requests while disabled and a mid-word loss of enable show how words are chained and how an abort is handled.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    // Line half-bits taken by the sync pattern and how many of them are high
    localparam int SYNC_HALVES      = 6;
    localparam int SYNC_HIGH_HALVES = 3;

    typedef enum logic {
        SYNC_DATA = 1'b0,
        SYNC_CMD  = 1'b1
    } sync_kind_e;

    // Manchester II: first half carries the bit, second half its complement
    function automatic logic mch_level(input logic bit_v, input logic second_half);
        return second_half ? ~bit_v : bit_v;
    endfunction

endpackage

// File: rtl/mwt_tick.sv
// Counts clocks inside one half-bit while a word is active
module mwt_tick #(
    parameter int HALF_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first_tick,
    output logic last_tick
);
    localparam int TICK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(HALF_TICKS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } tick_t;

    tick_t s_d, s_q;

    assign first_tick = run && (s_q.cnt == '0);
    assign last_tick  = run && (s_q.cnt == TICK_LAST);

    always_comb begin
        s_d = s_q;
        if (!run || last_tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mwt_seq.sv
// Word sequencer: active flag, half-bit index, latched sync choice, strobes
module mwt_seq #(
    parameter int WORD_HALVES = 40,
    parameter int SYNC_HALVES = 6,
    parameter int HALF_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_en,
    input  logic              send_req,
    input  logic              sync_cmd,
    input  logic              first_tick,
    input  logic              last_tick,
    output logic              active,
    output logic [HALF_W-1:0] half_idx,
    output logic              sync_sel,
    output logic              start_stb,
    output logic              data_stb,
    output logic              end_stb
);
    import mwt_pkg::*;

    localparam logic [HALF_W-1:0] HALF_FIRST   = '0;
    localparam logic [HALF_W-1:0] HALF_CAPTURE = HALF_W'(SYNC_HALVES - 1);
    localparam logic [HALF_W-1:0] HALF_FINAL   = HALF_W'(WORD_HALVES - 1);

    typedef struct packed {
        logic              active;
        sync_kind_e        sync;
        logic [HALF_W-1:0] half;
    } seq_t;

    seq_t s_d, s_q;
    logic go;

    assign go = enc_en && send_req;

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.half   = HALF_FIRST;
                s_d.sync   = sync_kind_e'(sync_cmd);
            end
        end else if (!enc_en) begin
            // enable lost: drop the word at once
            s_d.active = 1'b0;
            s_d.half   = HALF_FIRST;
        end else if (last_tick) begin
            if (s_q.half == HALF_FINAL) begin
                s_d.half = HALF_FIRST;
                if (send_req) begin
                    s_d.sync = sync_kind_e'(sync_cmd);
                end else begin
                    s_d.active = 1'b0;
                end
            end else begin
                s_d.half = s_q.half + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{active: 1'b0, sync: SYNC_DATA, half: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active    = s_q.active;
    assign half_idx  = s_q.half;
    assign sync_sel  = (s_q.sync == SYNC_CMD);
    assign start_stb = s_q.active && first_tick && (s_q.half == HALF_FIRST);
    assign data_stb  = s_q.active && last_tick && (s_q.half == HALF_CAPTURE);
    assign end_stb   = s_q.active && last_tick && (s_q.half == HALF_FINAL);
endmodule

// File: rtl/mwt_shift.sv
// Holds data plus parity; the most significant position is the bit on the line
module mwt_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_in,
    output logic              cur_bit
);
    typedef struct packed {
        logic [DATA_W:0] sh;
    } shift_t;

    shift_t s_d, s_q;
    logic   par_odd;

    // parity bit that makes the total count of ones odd
    assign par_odd = ~(^data_in);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh = {data_in, par_odd};
        end else if (shift) begin
            s_d.sh = {s_q.sh[DATA_W-1:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_bit = s_q.sh[DATA_W];
endmodule

// File: rtl/mwt_line.sv
// Chooses the line level for the current half-bit
module mwt_line #(
    parameter int HALF_W = 6
) (
    input  logic              active,
    input  logic [HALF_W-1:0] half_idx,
    input  logic              sync_sel,
    input  logic              cur_bit,
    output logic              tx_pos,
    output logic              tx_neg
);
    import mwt_pkg::*;

    localparam logic [HALF_W-1:0] SYNC_END = HALF_W'(SYNC_HALVES);
    localparam logic [HALF_W-1:0] SYNC_MID = HALF_W'(SYNC_HIGH_HALVES);

    logic level;

    always_comb begin
        if (half_idx < SYNC_END) begin
            level = (half_idx < SYNC_MID) ? sync_sel : ~sync_sel;
        end else begin
            // the sync takes an even number of halves, so bit 0 gives the phase
            level = mch_level(cur_bit, half_idx[0]);
        end
    end

    assign tx_pos = active & level;
    assign tx_neg = active & ~level;
endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx #(
    parameter int DATA_W     = 16,
    parameter int HALF_TICKS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_en,
    input  logic              send_req,
    input  logic              sync_cmd,
    input  logic [DATA_W-1:0] data_in,
    output logic              tx_pos,
    output logic              tx_neg,
    output logic              start_stb,
    output logic              data_stb,
    output logic              end_stb
);
    import mwt_pkg::*;

    localparam int WORD_HALVES = SYNC_HALVES + 2 * (DATA_W + 1);
    localparam int HALF_W      = $clog2(WORD_HALVES);
    localparam logic [HALF_W-1:0] FIRST_BIT_HALF = HALF_W'(SYNC_HALVES);

    logic              word_active;
    logic [HALF_W-1:0] half_idx;
    logic              sync_sel;
    logic              first_tick;
    logic              last_tick;
    logic              cur_bit;
    logic              shift_now;

    mwt_tick #(.HALF_TICKS(HALF_TICKS)) i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (word_active),
        .first_tick (first_tick),
        .last_tick  (last_tick)
    );

    mwt_seq #(
        .WORD_HALVES (WORD_HALVES),
        .SYNC_HALVES (SYNC_HALVES),
        .HALF_W      (HALF_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_en     (enc_en),
        .send_req   (send_req),
        .sync_cmd   (sync_cmd),
        .first_tick (first_tick),
        .last_tick  (last_tick),
        .active     (word_active),
        .half_idx   (half_idx),
        .sync_sel   (sync_sel),
        .start_stb  (start_stb),
        .data_stb   (data_stb),
        .end_stb    (end_stb)
    );

    // advance to the next bit at the end of each second half
    assign shift_now = last_tick && half_idx[0] && (half_idx > FIRST_BIT_HALF);

    mwt_shift #(.DATA_W(DATA_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (data_stb && enc_en),
        .shift   (shift_now),
        .data_in (data_in),
        .cur_bit (cur_bit)
    );

    mwt_line #(.HALF_W(HALF_W)) i_line (
        .active   (word_active),
        .half_idx (half_idx),
        .sync_sel (sync_sel),
        .cur_bit  (cur_bit),
        .tx_pos   (tx_pos),
        .tx_neg   (tx_neg)
    );
endmodule

// File: rtl/mwt_checker.sv
module mwt_checker #(
    parameter int DATA_W     = 16,
    parameter int HALF_TICKS = 25
) (
    input logic clk,
    input logic rst_n,
    input logic enc_en,
    input logic send_req,
    input logic active,
    input logic tx_pos,
    input logic tx_neg,
    input logic start_stb,
    input logic data_stb,
    input logic end_stb
);
    localparam int WORD_CLKS = (6 + 2 * (DATA_W + 1)) * HALF_TICKS;

    int unsigned since_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= 0;
        end else if (start_stb) begin
            since_start <= 1;
        end else if (active) begin
            since_start <= since_start + 1;
        end else begin
            since_start <= 0;
        end
    end

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!tx_pos && !tx_neg && !start_stb && !data_stb && !end_stb);
        end
    end

    p_start_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> $past(enc_en && send_req));

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !start_stb);

    p_word_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |-> (since_start == WORD_CLKS - 1));

    p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stb, data_stb, end_stb}));

    p_chain_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && enc_en && send_req) |=> start_stb);

    p_pair_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (tx_pos != tx_neg));

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!tx_pos && !tx_neg));

    p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_en |=> (!tx_pos && !tx_neg && !start_stb && !end_stb));
endmodule

bind manch_word_tx mwt_checker #(
    .DATA_W     (DATA_W),
    .HALF_TICKS (HALF_TICKS)
) i_mwt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_en    (enc_en),
    .send_req  (send_req),
    .active    (word_active),
    .tx_pos    (tx_pos),
    .tx_neg    (tx_neg),
    .start_stb (start_stb),
    .data_stb  (data_stb),
    .end_stb   (end_stb)
);

// File: tb/test_manch_word_tx.sv
`timescale 1ns/1ps
module test_manch_word_tx;
    localparam int DW    = 16;
    localparam int HT    = 25;
    localparam int WORDH = 6 + 2 * (DW + 1);
    localparam int WCLK  = WORDH * HT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_en = 1'b0;
    logic          send_req = 1'b0;
    logic          sync_cmd = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          tx_pos, tx_neg, start_stb, data_stb, end_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    manch_word_tx #(.DATA_W(DW), .HALF_TICKS(HT)) i_manch_word_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enc_en    (enc_en),
        .send_req  (send_req),
        .sync_cmd  (sync_cmd),
        .data_in   (data_in),
        .tx_pos    (tx_pos),
        .tx_neg    (tx_neg),
        .start_stb (start_stb),
        .data_stb  (data_stb),
        .end_stb   (end_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Expected tx_pos level in half-bit h, from the requirements
    function automatic logic exp_level(input logic s, input logic [DW-1:0] d, input int h);
        logic b;
        if (h < 6) return s ? (h < 3) : (h >= 3);
        if ((h - 6) / 2 < DW) b = d[DW - 1 - (h - 6) / 2];
        else                  b = ~(^d);
        return (h % 2 == 0) ? b : ~b;
    endfunction

    // Called at the negedge where start_stb should be high (offset 0).
    // Returns at the negedge of offset WCLK.
    task automatic run_word(input logic s, input logic [DW-1:0] d,
                            input bit hold_req, input logic next_s, input string tag);
        for (int k = 0; k < WCLK; k++) begin
            int h = k / HT;
            int t = k % HT;
            if (k == 0) chk(start_stb == 1'b1, "R2", {tag, " start_stb at word start"}, int'(start_stb), 1);
            if (k == 1) begin
                chk(start_stb == 1'b0, "R2", {tag, " start_stb one cycle"}, int'(start_stb), 0);
                sync_cmd = ~s;                      // late change must not matter (R3)
            end
            if (t == HT / 2) begin
                logic e = exp_level(s, d, h);
                string rq = (h < 6) ? "R3" : ((h < 38) ? "R4" : "R5");
                chk(tx_pos == e, rq, $sformatf("%s tx_pos half %0d", tag, h), int'(tx_pos), int'(e));
                chk(tx_neg == ~tx_pos, "R9", $sformatf("%s tx_neg half %0d", tag, h), int'(tx_neg), int'(~tx_pos));
            end
            if (k == 6 * HT - 1) begin
                chk(data_stb == 1'b1, "R6", {tag, " data_stb in capture cycle"}, int'(data_stb), 1);
                data_in = d;
            end
            if (k == 6 * HT) begin
                chk(data_stb == 1'b0, "R6", {tag, " data_stb after capture"}, int'(data_stb), 0);
                data_in = ~d ^ 16'h5A5A;            // decoy after capture (R6)
                if (!hold_req) send_req = 1'b0;
            end
            if (k == WCLK - 2) chk(end_stb == 1'b0, "R7", {tag, " end_stb early"}, int'(end_stb), 0);
            if (k == WCLK - 1) begin
                chk(end_stb == 1'b1, "R7", {tag, " end_stb at last clock"}, int'(end_stb), 1);
                sync_cmd = next_s;
                data_in  = ~(hold_req ? d : ~d); // decoy for any following sync
            end
            @(negedge clk);
        end
    endtask

    task automatic begin_word(input logic s, input logic [DW-1:0] d, input string tag);
        enc_en   = 1'b1;
        send_req = 1'b1;
        sync_cmd = s;
        data_in  = ~d;                              // decoy before capture (R6)
        @(negedge clk);
        chk(start_stb == 1'b1, "R2", {tag, " start one cycle after request"}, int'(start_stb), 1);
    endtask

    task automatic check_idle(input string tag, input int cycles);
        bit bad = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if (tx_pos || tx_neg || start_stb || data_stb || end_stb) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R9", {tag, " idle outputs stay low"}, int'(bad), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!tx_pos && !tx_neg, "R1", "line low in reset", int'({tx_pos, tx_neg}), 0);
        chk(!start_stb && !data_stb && !end_stb, "R1", "strobes low in reset",
            int'({start_stb, data_stb, end_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset", 5);
    endtask

    task automatic t_cmd_word();
        begin_word(1'b1, 16'hA5C3, "cmd A5C3");
        run_word(1'b1, 16'hA5C3, 1'b0, 1'b0, "cmd A5C3");
        chk(!start_stb && !tx_pos && !tx_neg, "R8", "no restart without request",
            int'({start_stb, tx_pos, tx_neg}), 0);
        check_idle("after cmd word", 20);
    endtask

    task automatic t_data_word();
        begin_word(1'b0, 16'h0000, "data 0000");
        run_word(1'b0, 16'h0000, 1'b0, 1'b1, "data 0000");
        check_idle("after data word", 20);
    endtask

    task automatic t_back_to_back();
        begin_word(1'b1, 16'hFFFF, "chain FFFF");
        run_word(1'b1, 16'hFFFF, 1'b1, 1'b0, "chain FFFF");
        chk(start_stb == 1'b1, "R8", "next word starts with no gap", int'(start_stb), 1);
        run_word(1'b0, 16'h0001, 1'b0, 1'b0, "chain 0001");
        check_idle("after chain", 20);
    endtask

    task automatic t_enable_gate();
        bit seen = 1'b0;
        enc_en   = 1'b0;
        send_req = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (start_stb || tx_pos || tx_neg) seen = 1'b1;
        end
        chk(!seen, "R10", "no word while disabled", int'(seen), 0);
        begin_word(1'b1, 16'h1234, "abort");
        repeat (299) @(negedge clk);
        chk(tx_pos != tx_neg, "R9", "line driven mid word", int'(tx_pos ^ tx_neg), 1);
        enc_en = 1'b0;
        @(negedge clk);
        chk(!tx_pos && !tx_neg, "R10", "line low after enable drop", int'({tx_pos, tx_neg}), 0);
        seen = 1'b0;
        for (int i = 0; i < WCLK + 100; i++) begin
            if (end_stb || start_stb || tx_pos || tx_neg) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R10", "no end strobe or restart after abort", int'(seen), 0);
        send_req = 1'b0;
        enc_en   = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..: actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cmd_word();
        t_data_word();
        t_back_to_back();
        t_enable_gate();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule